// File: doc/BRIEF.md
# USB Host Port Electrical Test Mode Sequencer

This block holds the control fields that place a USB 2.0 host port into one of its electrical compliance test modes, and it checks that software programs them in the required order. A CPU writes three small registers over a plain write-only bus. The control register holds the clock enable, host select, pulldown enable, module enable and port activity enable. The selector register holds a 4-bit test code. The status register is written to clear a protocol-violation flag. Separate inputs carry the NAK state of every pipe and a high-speed disconnect indication.

The outputs go to the line-level logic that sits around the block. One output selects which test pattern to drive. The others enable high-speed termination and start-of-frame generation, and pass on the disconnect event when the hardware may react to it. Test mode is entered only when software follows the enable order. A test code is latched when the port is activated, and from then on only a power-on reset returns the port to normal traffic. Any step taken out of order, or a selector write while some pipe is not NAKing, sets a sticky violation flag.

Top module: `usb_test_mode_ctrl`

## Requirements
- R1: After reset every register field is 0, no test mode is latched, and patSel, hsTermEn, sofEn, discAct and violation are all 0.
- R2: A write to the selector register (wrAddr 1, code in wrData[3:0]) is dropped unless host select (ctrl bit 1) and pulldown enable (ctrl bit 2) are both already 1.
- R3: patSel is nonzero and hsTermEn is 1 only while a test mode is latched and both pulldown enable and port activity enable (ctrl bit 4) are 1.
- R4: The first entry must follow this order: clock enable (ctrl bit 0), then host select and pulldown, then module enable (ctrl bit 3), then the selector, then port activity. Raising a field before the fields it depends on sets violation. This includes writing the selector while the port is active.
- R5: To switch test codes, software clears port activity and module enable, sets module enable again, writes the new code, and then sets port activity. The new code then takes effect and violation stays 0.
- R6: While code 1011 (SE0 with NAK, patSel 3) is latched, sofEn stays 0 even with the port active.
- R7: While code 1101 (forced enable, patSel 0) is latched, sofEn equals port liveness and discAct stays 0 whatever hsDisconnect does.
- R8: A selector write made while any pipeNak bit is 0 sets violation.
- R9: Raising port activity with a nonzero stored code latches that code. Later writes of 0000 followed by reactivation keep the latched test behaviour until power-on reset.
- R10: A latched 1001 gives patSel 1, 1010 gives 2, 1100 gives 3'd4, and 1011 gives 3. Other nonzero codes except 1101 give patSel 0 and hsTermEn 0.
- R11: Writing 1 to status bit 0 (wrAddr 2) clears violation. A violation detected in the same cycle wins.
- R12: With no test latched, sofEn is clock, host, module and port enables all 1, and discAct is hsDisconnect gated by host select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 selector, 2 status |
| wrData | input | 5 | Write data |
| pipeNak | input | NUM_PIPES | 1 per pipe whose response state is NAK |
| hsDisconnect | input | 1 | High-speed disconnect detected |
| patSel | output | 3 | Test pattern: 0 none, 1 J, 2 K, 3 SE0/NAK, 4 packet |
| hsTermEn | output | 1 | High-speed termination enable |
| sofEn | output | 1 | Start-of-frame generation enable |
| discAct | output | 1 | Disconnect passed on for hardware reaction |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The assertions assume single-cycle write strobes with a stable address and data. They also assume pipeNak is steady around a selector write, so the value seen at the write edge is the one that counts. The bench drives every write on the falling edge and holds it for exactly one cycle. It changes pipeNak and hsDisconnect only between writes. It sweeps all sixteen selector codes through the full entry and re-arm procedure, both with and without a disconnect.

// File: rtl/utm_pkg.sv
package utm_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 5;
  localparam int CODE_W = 4;
  localparam int PAT_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam logic [CODE_W-1:0] CODE_NORMAL = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_J      = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_K      = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_SE0NAK = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_PACKET = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_FORCE  = 4'b1101;

  typedef enum logic [PAT_W-1:0] {
    PAT_NONE   = 3'd0,
    PAT_J      = 3'd1,
    PAT_K      = 3'd2,
    PAT_SE0    = 3'd3,
    PAT_PACKET = 3'd4
  } pat_e;

  // first member is the MSB: clkEn sits in bit 0
  typedef struct packed {
    logic portAct;
    logic modEn;
    logic pullEn;
    logic hostSel;
    logic clkEn;
  } ctrl_t;

  typedef struct packed {
    logic ctrlWr;
    logic selWr;
    logic lockNow;
  } strobe_t;
endpackage

// File: rtl/utm_seq.sv
module utm_seq
  import utm_pkg::*;
#(
  parameter int NUM_PIPES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_PIPES-1:0] pipeNak,
  input  ctrl_t             ctrlQ,
  input  logic [CODE_W-1:0] selQ,
  output strobe_t           strb,
  output logic              locked,
  output logic              violation
);
  logic ctrlHit, selHit, statHit;
  ctrl_t nv;
  logic hostReady, portOk, selOrderOk, allNak;
  logic riseHost, risePull, riseMod, risePort;
  logic ctrlBad, selBad;
  logic selWritten, rearmed;

  always_comb begin
    ctrlHit   = wrEn && (wrAddr == ADDR_CTRL);
    selHit    = wrEn && (wrAddr == ADDR_SEL);
    statHit   = wrEn && (wrAddr == ADDR_STAT);
    nv        = ctrl_t'(wrData);
    allNak    = &pipeNak;
    hostReady = ctrlQ.clkEn && ctrlQ.hostSel && ctrlQ.pullEn;

    riseHost  = nv.hostSel && !ctrlQ.hostSel;
    risePull  = nv.pullEn  && !ctrlQ.pullEn;
    riseMod   = nv.modEn   && !ctrlQ.modEn;
    risePort  = nv.portAct && !ctrlQ.portAct;

    portOk    = hostReady && ctrlQ.modEn &&
                (selWritten || (!locked && (selQ == CODE_NORMAL)));
    selOrderOk = hostReady && ctrlQ.modEn && !ctrlQ.portAct &&
                 (!locked || rearmed);

    ctrlBad = ctrlHit && (
                ((riseHost || risePull) && !ctrlQ.clkEn) ||
                (riseMod && (!hostReady || ctrlQ.portAct)) ||
                (risePort && !portOk));
    selBad  = selHit && (!selOrderOk || !allNak);

    strb.ctrlWr  = ctrlHit;
    strb.selWr   = selHit && ctrlQ.hostSel && ctrlQ.pullEn;
    strb.lockNow = ctrlHit && risePort && !ctrlBad && (selQ != CODE_NORMAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selWritten <= 1'b0;
      rearmed    <= 1'b0;
      locked     <= 1'b0;
      violation  <= 1'b0;
    end else begin
      if (ctrlHit && !nv.modEn)
        selWritten <= 1'b0;
      else if (strb.selWr)
        selWritten <= 1'b1;

      if (strb.lockNow)
        rearmed <= 1'b0;
      else if (ctrlHit && locked && riseMod && !ctrlQ.portAct)
        rearmed <= 1'b1;

      if (strb.lockNow)
        locked <= 1'b1;

      if (ctrlBad || selBad)
        violation <= 1'b1;
      else if (statHit && wrData[0])
        violation <= 1'b0;
    end
  end
endmodule

// File: rtl/utm_datapath.sv
module utm_datapath
  import utm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              locked,
  input  logic              hsDisconnect,
  output ctrl_t             ctrlQ,
  output logic [CODE_W-1:0] selQ,
  output logic [CODE_W-1:0] lockedCode,
  output logic [PAT_W-1:0]  patSel,
  output logic              hsTermEn,
  output logic              sofEn,
  output logic              discAct
);
  pat_e pat;
  logic codeValid, isForce, portLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ      <= '0;
      selQ       <= CODE_NORMAL;
      lockedCode <= CODE_NORMAL;
    end else begin
      if (strb.ctrlWr)  ctrlQ      <= ctrl_t'(wrData);
      if (strb.selWr)   selQ       <= wrData[CODE_W-1:0];
      if (strb.lockNow) lockedCode <= selQ;
    end
  end

  always_comb begin
    pat       = PAT_NONE;
    codeValid = 1'b1;
    isForce   = 1'b0;
    case (lockedCode)
      CODE_J:      pat = PAT_J;
      CODE_K:      pat = PAT_K;
      CODE_SE0NAK: pat = PAT_SE0;
      CODE_PACKET: pat = PAT_PACKET;
      CODE_FORCE:  isForce = 1'b1;
      default:     codeValid = 1'b0;
    endcase

    portLive = ctrlQ.pullEn && ctrlQ.portAct;
    patSel   = (locked && portLive) ? PAT_W'(pat) : PAT_W'(PAT_NONE);
    hsTermEn = locked && portLive && codeValid;
    if (locked)
      sofEn = isForce && portLive;
    else
      sofEn = ctrlQ.clkEn && ctrlQ.hostSel && ctrlQ.modEn && ctrlQ.portAct;
    discAct  = hsDisconnect && ctrlQ.hostSel && !(locked && isForce);
  end
endmodule

// File: rtl/usb_test_mode_ctrl.sv
module usb_test_mode_ctrl
  import utm_pkg::*;
#(
  parameter int NUM_PIPES = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_PIPES-1:0] pipeNak,
  input  logic                 hsDisconnect,
  output logic [PAT_W-1:0]     patSel,
  output logic                 hsTermEn,
  output logic                 sofEn,
  output logic                 discAct,
  output logic                 violation
);
  strobe_t strb;
  ctrl_t ctrlQ;
  logic [CODE_W-1:0] selQ, lockedCode;
  logic locked;

  utm_seq #(.NUM_PIPES(NUM_PIPES)) uSeq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pipeNak(pipeNak), .ctrlQ(ctrlQ), .selQ(selQ), .strb(strb),
    .locked(locked), .violation(violation)
  );

  utm_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .locked(locked),
    .hsDisconnect(hsDisconnect), .ctrlQ(ctrlQ), .selQ(selQ),
    .lockedCode(lockedCode), .patSel(patSel), .hsTermEn(hsTermEn),
    .sofEn(sofEn), .discAct(discAct)
  );
endmodule

// File: rtl/utm_checker.sv
module utm_checker
  import utm_pkg::*;
#(
  parameter int NUM_PIPES = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [NUM_PIPES-1:0] pipeNak,
  input ctrl_t                ctrlQ,
  input logic [CODE_W-1:0]    selQ,
  input logic                 locked,
  input logic [CODE_W-1:0]    lockedCode,
  input logic [PAT_W-1:0]     patSel,
  input logic                 hsTermEn,
  input logic                 sofEn,
  input logic                 discAct,
  input logic                 violation
);
  AST_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == ADDR_SEL && !(ctrlQ.hostSel && ctrlQ.pullEn) |=> $stable(selQ)); // R2
  AST_TERM_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    hsTermEn |-> ctrlQ.pullEn && ctrlQ.portAct && locked); // R3
  AST_PAT_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rstN)
    patSel != '0 |-> hsTermEn); // R3
  AST_SE0_NO_SOF: assert property (@(posedge clk) disable iff (!rstN)
    locked && lockedCode == CODE_SE0NAK |-> !sofEn); // R6
  AST_FORCE_NO_DISC: assert property (@(posedge clk) disable iff (!rstN)
    locked && lockedCode == CODE_FORCE |-> !discAct); // R7
  AST_BAD_PIPE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == ADDR_SEL && !(&pipeNak) |=> violation); // R8
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R9
  AST_LOCK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> lockedCode != CODE_NORMAL); // R9
endmodule

bind usb_test_mode_ctrl utm_checker #(.NUM_PIPES(NUM_PIPES)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .pipeNak(pipeNak),
  .ctrlQ(ctrlQ), .selQ(selQ), .locked(locked), .lockedCode(lockedCode),
  .patSel(patSel), .hsTermEn(hsTermEn), .sofEn(sofEn), .discAct(discAct),
  .violation(violation)
);

// File: tb/tb_usb_test_mode_ctrl.sv
module tb_usb_test_mode_ctrl;
  localparam int NP = 10;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [4:0] wrData = '0;
  logic [NP-1:0] pipeNak = '1;
  logic hsDisconnect = 1'b0;
  logic [2:0] patSel;
  logic hsTermEn, sofEn, discAct, violation;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_test_mode_ctrl #(.NUM_PIPES(NP)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pipeNak(pipeNak), .hsDisconnect(hsDisconnect), .patSel(patSel),
    .hsTermEn(hsTermEn), .sofEn(sofEn), .discAct(discAct), .violation(violation)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; wrEn = 1'b0; pipeNak = '1; hsDisconnect = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    #1;
  endtask

  function automatic int expPat(input logic [3:0] c);
    case (c)
      4'b1001: return 1;
      4'b1010: return 2;
      4'b1011: return 3;
      4'b1100: return 4;
      default: return 0;
    endcase
  endfunction
  function automatic int expTerm(input logic [3:0] c);
    return (expPat(c) != 0 || c == 4'b1101) ? 1 : 0;
  endfunction
  function automatic int expSof(input logic [3:0] c);
    return (c == 4'b0000 || c == 4'b1101) ? 1 : 0;
  endfunction
  function automatic int expDisc(input logic [3:0] c, input logic d);
    return (d && c != 4'b1101) ? 1 : 0;
  endfunction

  task automatic enter(input logic [3:0] code);
    wr(2'd0, 5'h01); wr(2'd0, 5'h07); wr(2'd0, 5'h0F);
    wr(2'd1, {1'b0, code}); wr(2'd0, 5'h1F);
  endtask

  initial begin
    doReset();
    #1;
    chk("R1 patSel", patSel, 0); chk("R1 hsTermEn", hsTermEn, 0);
    chk("R1 sofEn", sofEn, 0); chk("R1 discAct", discAct, 0);
    chk("R1 violation", violation, 0);

    // full sweep of selector codes: entry, deactivate, re-arm with 0000
    for (int c = 0; c < 16; c++) begin
      for (int d = 0; d < 2; d++) begin
        doReset();
        enter(4'(c));
        hsDisconnect = 1'(d); #1;
        chk("R4 no violation on ordered entry", violation, 0);
        chk("R10 patSel", patSel, expPat(4'(c)));
        chk("R3 hsTermEn", hsTermEn, expTerm(4'(c)));
        chk("R6/R7/R12 sofEn", sofEn, expSof(4'(c)));
        chk("R7/R12 discAct", discAct, expDisc(4'(c), 1'(d)));
        hsDisconnect = 1'b0;
        wr(2'd0, 5'h07);
        chk("R3 patSel with port idle", patSel, 0);
        chk("R3 hsTermEn with port idle", hsTermEn, 0);
        wr(2'd0, 5'h0F); wr(2'd1, 5'h00); wr(2'd0, 5'h1F);
        hsDisconnect = 1'(d); #1;
        chk("R5 violation after re-arm", violation, 0);
        chk("R9 patSel kept", patSel, expPat(4'(c)));
        chk("R9 hsTermEn kept", hsTermEn, expTerm(4'(c)));
        chk("R9 sofEn kept", sofEn, expSof(4'(c)));
        chk("R9 discAct kept", discAct, expDisc(4'(c), 1'(d)));
      end
    end

    // R5: switch J to K through the change procedure
    doReset(); enter(4'b1001);
    wr(2'd0, 5'h07); wr(2'd0, 5'h0F); wr(2'd1, 5'b01010); wr(2'd0, 5'h1F);
    chk("R5 new code patSel", patSel, 2); chk("R5 violation", violation, 0);

    // R5/R4: selector write while still active is out of order
    doReset(); enter(4'b1001);
    wr(2'd1, 5'b01010);
    chk("R4 selector while active", violation, 1);
    wr(2'd2, 5'h01);
    chk("R11 clear by write one", violation, 0);

    // R4: module enable before host/pulldown
    doReset(); wr(2'd0, 5'h01); wr(2'd0, 5'h0F);
    chk("R4 module before host", violation, 1);
    wr(2'd2, 5'h00);
    chk("R11 write zero keeps flag", violation, 1);
    // R4: host select before clock
    doReset(); wr(2'd0, 5'h06);
    chk("R4 host before clock", violation, 1);

    // R2: selector write dropped without host/pulldown
    doReset(); wr(2'd0, 5'h01); wr(2'd1, 5'b01001);
    wr(2'd2, 5'h01);
    wr(2'd0, 5'h07); wr(2'd0, 5'h0F); wr(2'd0, 5'h1F);
    chk("R2 dropped code patSel", patSel, 0);
    chk("R2 normal sofEn", sofEn, 1);
    chk("R2 no violation afterwards", violation, 0);

    // R8: each pipe not NAK at selector write
    for (int p = 0; p < NP; p++) begin
      doReset();
      wr(2'd0, 5'h01); wr(2'd0, 5'h07); wr(2'd0, 5'h0F);
      pipeNak = '1; pipeNak[p] = 1'b0;
      wr(2'd1, 5'b01001);
      chk("R8 pipe not NAK", violation, 1);
      pipeNak = '1;
      wr(2'd2, 5'h01);
      wr(2'd1, 5'b01001);
      chk("R8 all NAK", violation, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule